// File: doc/BRIEF.md
# Two-Level SCL Bit-Timing Generator

This block derives the bit timing for an I2C master engine from the peripheral clock. A prescaler divides the peripheral clock by one plus a small divide code and gives a one-cycle internal tick. A second counter runs on those ticks and marks out one SCL period. The period is a fixed base of twenty ticks, plus eight ticks for each step of a six-bit stretch code, plus a compensation count that covers the line's rise time, fall time and internal delay. The period is split into a low phase and a high phase. The master engine receives a strobe as each phase begins and a level that tells it which phase is current.

Software writes one packed control word. The divide code sits in the low bits and the stretch code sits directly above it. The divide field is two or three bits wide, set by a parameter. The compensation count is sampled on the same write. A write restarts both counters, so the new setting applies from the next full SCL period. A slave may hold the SCL line low to stretch the clock. While the synchronized SCL line is still low during the high phase, the count is held.

Top module: `scl_clkgen`

## Requirements
- R1: `tick_o` pulses for one cycle once every 1 + D cycles, where D is the divide code. With D = 0 it stays high.
- R2: The control word `cfg_wdata` holds D in bits [DIV_W-1:0] and the 6-bit stretch code S in bits [DIV_W+5:DIV_W]. DIV_W is 2 or 3.
- R3: One SCL period lasts P = 20 + 8·S + C internal ticks, where C is the compensation count sampled from `cfg_comp` on the write.
- R4: The low phase lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks, so an odd P gives its extra tick to the low phase.
- R5: `scl_low_stb_o` and `scl_high_stb_o` are one-cycle pulses, one at the start of each phase. They are never high together. `scl_hi_o` is 1 throughout the high phase.
- R6: In the cycle after a write, `scl_low_stb_o` is 1 and `scl_hi_o` is 0. Both counters start from zero, so the first `scl_high_stb_o` comes (1 + D)·ceil(P/2) + 1 cycles after that low strobe.
- R7: During the high phase, while the synchronized `scl_in` is 0, the period count holds. No low strobe occurs until the line has been high for floor(P/2) ticks.
- R8: A low `scl_in` during the low phase has no effect on the length of the low phase.
- R9: Reset is synchronous and active high. It clears all outputs to 0 and loads the default setting D = 0, S = 0, C = 0. The first high strobe after reset comes 11 cycles after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | DIV_W+6 | Packed control word: stretch code above the divide code |
| cfg_comp | input | COMP_W | Compensation ticks, sampled on a write |
| scl_in | input | 1 | Sampled SCL line, asynchronous |
| tick_o | output | 1 | Internal tick strobe |
| scl_low_stb_o | output | 1 | Start-of-low-phase strobe |
| scl_high_stb_o | output | 1 | Start-of-high-phase strobe |
| scl_hi_o | output | 1 | High-phase level |

## Verification
The case that is hardest to reach is a slave holding the clock low. It only matters while the count is inside the high phase, and it takes effect through the synchronizer, a few cycles late. The bench holds `scl_in` low across a whole control write. It first confirms that the low phase keeps its length (R8). Then, after the high strobe, it waits a long time and checks that no low strobe appears. It then releases the line and checks that the next low strobe falls within a window set by the high length plus the synchronizer delay. The other cases come from a table of settings that covers the smallest and largest stretch codes, the largest divide code, and both odd and even periods.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} ph_e;
  localparam int BASE_TICKS = 20;
  localparam int STEP_TICKS = 8;
endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg #(
  parameter int DIV_W    = 3,
  parameter int STR_W    = 6,
  parameter int COMP_W   = 4,
  parameter int PER_W    = 10,
  parameter int RST_DIV  = 0,
  parameter int RST_STR  = 0,
  parameter int RST_COMP = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [DIV_W+STR_W-1:0] wdata,
  input  logic [COMP_W-1:0]      comp_in,
  output logic [DIV_W-1:0]       div_o,
  output logic [PER_W-1:0]       low_len_o,
  output logic [PER_W-1:0]       high_len_o
);
  import ckdiv_pkg::*;

  logic [STR_W-1:0] str_w;
  logic [PER_W-1:0] per_w;
  logic [PER_W-1:0] per_rst;
  logic [PER_W-1:0] per_q;

  assign str_w   = wdata[DIV_W+STR_W-1:DIV_W];
  assign per_w   = PER_W'(BASE_TICKS) + PER_W'(STEP_TICKS) * PER_W'(str_w) + PER_W'(comp_in);
  assign per_rst = PER_W'(BASE_TICKS + STEP_TICKS * RST_STR + RST_COMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o <= DIV_W'(RST_DIV);
      per_q <= per_rst;
    end else if (we) begin
      div_o <= wdata[DIV_W-1:0];
      per_q <= per_w;
    end
  end

  assign high_len_o = per_q >> 1;
  assign low_len_o  = per_q - (per_q >> 1);

  // R2: divide field taken from the low bits of the word
  a_r2_div_field: assert property (@(posedge clk) disable iff (rst)
    we |=> (div_o == $past(wdata[DIV_W-1:0])));
  // R4: split never lets the high phase exceed the low phase
  a_r4_split_order: assert property (@(posedge clk) disable iff (rst)
    (high_len_o <= low_len_o) && (low_len_o - high_len_o <= 1));
endmodule

// File: rtl/ckdiv_prescale.sv
module ckdiv_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == div) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R1: a nonzero divide code never gives back-to-back ticks
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick_o && (div != '0) && !restart) |=> !tick_o);
  // R1: the count stays inside the divide range
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (cnt <= div));
endmodule

// File: rtl/ckdiv_sync.sv
module ckdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ckdiv_phase.sv
module ckdiv_phase #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic             scl_ok,
  input  logic [PER_W-1:0] low_len,
  input  logic [PER_W-1:0] high_len,
  output logic             low_stb_o,
  output logic             high_stb_o,
  output logic             scl_hi_o
);
  import ckdiv_pkg::*;

  ph_e              phase;
  logic [PER_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_LOW;
      pcnt       <= '0;
      low_stb_o  <= 1'b0;
      high_stb_o <= 1'b0;
    end else if (restart) begin
      phase      <= PH_LOW;
      pcnt       <= '0;
      low_stb_o  <= 1'b1;
      high_stb_o <= 1'b0;
    end else begin
      low_stb_o  <= 1'b0;
      high_stb_o <= 1'b0;
      if (tick) begin
        case (phase)
          PH_LOW: begin
            if (pcnt == low_len - 1'b1) begin
              phase      <= PH_HIGH;
              pcnt       <= '0;
              high_stb_o <= 1'b1;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          default: begin
            if (scl_ok) begin
              if (pcnt == high_len - 1'b1) begin
                phase     <= PH_LOW;
                pcnt      <= '0;
                low_stb_o <= 1'b1;
              end else begin
                pcnt <= pcnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign scl_hi_o = (phase == PH_HIGH);

  // R5: phase strobes are exclusive
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(low_stb_o && high_stb_o));
  // R6: a write starts a fresh low phase
  a_r6_restart_low: assert property (@(posedge clk) disable iff (rst)
    restart |=> (low_stb_o && !scl_hi_o));
  // R7: a held-low line keeps the high phase alive
  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (rst)
    (scl_hi_o && !scl_ok && !restart) |=> (scl_hi_o && !low_stb_o));
  // R4: low count stays below the low length
  a_r4_low_bound: assert property (@(posedge clk) disable iff (rst)
    (!scl_hi_o && !restart) |=> (scl_hi_o || (pcnt < low_len)));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int DIV_W       = 3,
  parameter int COMP_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_DIV     = 0,
  parameter int RST_STR     = 0,
  parameter int RST_COMP    = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [DIV_W+5:0]      cfg_wdata,
  input  logic [COMP_W-1:0]     cfg_comp,
  input  logic                  scl_in,
  output logic                  tick_o,
  output logic                  scl_low_stb_o,
  output logic                  scl_high_stb_o,
  output logic                  scl_hi_o
);
  localparam int STR_W   = 6;
  localparam int MAX_PER = 20 + 8 * ((1 << STR_W) - 1) + ((1 << COMP_W) - 1);
  localparam int PER_W   = $clog2(MAX_PER + 1);

  logic [DIV_W-1:0] div;
  logic [PER_W-1:0] low_len;
  logic [PER_W-1:0] high_len;
  logic             scl_ok;

  ckdiv_cfg #(
    .DIV_W(DIV_W), .STR_W(STR_W), .COMP_W(COMP_W), .PER_W(PER_W),
    .RST_DIV(RST_DIV), .RST_STR(RST_STR), .RST_COMP(RST_COMP)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .comp_in(cfg_comp),
    .div_o(div), .low_len_o(low_len), .high_len_o(high_len)
  );

  ckdiv_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .restart(cfg_we), .div(div), .tick_o(tick_o)
  );

  ckdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_ok)
  );

  ckdiv_phase #(.PER_W(PER_W)) u_phase (
    .clk(clk), .rst(rst), .restart(cfg_we), .tick(tick_o), .scl_ok(scl_ok),
    .low_len(low_len), .high_len(high_len),
    .low_stb_o(scl_low_stb_o), .high_stb_o(scl_high_stb_o), .scl_hi_o(scl_hi_o)
  );
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic [3:0] cfg_comp = '0;
  logic       scl_in = 1'b1;
  logic       tick_o, scl_low_stb_o, scl_high_stb_o, scl_hi_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  scl_clkgen #(.DIV_W(3), .COMP_W(4), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_comp(cfg_comp), .scl_in(scl_in), .tick_o(tick_o),
    .scl_low_stb_o(scl_low_stb_o), .scl_high_stb_o(scl_high_stb_o),
    .scl_hi_o(scl_hi_o)
  );

  // div, stretch, comp, first-low cycles, high cycles, low cycles, tick gap
  localparam int unsigned TV [0:5][0:6] = '{
    '{0,  0,  0,  11,  10,  10, 1},
    '{1,  1,  3,  33,  30,  32, 2},
    '{7,  0,  1,  89,  80,  88, 8},
    '{2,  2,  5,  64,  60,  63, 3},
    '{0, 63, 15, 271, 269, 270, 1},
    '{3,  3,  0,  89,  88,  88, 4}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // which: 0 low strobe, 1 high strobe, 2 tick
  task automatic wait_sig(input int which, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if ((which == 0 && scl_low_stb_o) || (which == 1 && scl_high_stb_o) ||
          (which == 2 && tick_o))
        break;
    end
  endtask

  task automatic write_cfg(input int dv, input int st, input int cp);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {6'(st), 3'(dv)};
    cfg_comp  = 4'(cp);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  initial begin
    int n;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 tick", int'(tick_o), 0);
    check("R9 low_stb", int'(scl_low_stb_o), 0);
    check("R9 high_stb", int'(scl_high_stb_o), 0);
    check("R9 scl_hi", int'(scl_hi_o), 0);
    rst = 1'b0;
    wait_sig(1, 2000, n);
    check("R9 default first high", n, 11);

    for (int i = 0; i < 6; i++) begin
      write_cfg(int'(TV[i][0]), int'(TV[i][1]), int'(TV[i][2]));
      check("R6 low strobe after write", int'(scl_low_stb_o), 1);
      wait_sig(1, 5000, n);
      check("R6 first low length", n, int'(TV[i][3]));
      check("R5 level at high strobe", int'(scl_hi_o), 1);
      wait_sig(0, 5000, n);
      check("R4 high length", n, int'(TV[i][4]));
      wait_sig(1, 5000, n);
      check("R3 low length", n, int'(TV[i][5]));
      wait_sig(2, 50, n);
      wait_sig(2, 50, n);
      check("R1 R2 tick spacing", n, int'(TV[i][6]));
    end

    // stretch: line held low across a write
    scl_in = 1'b0;
    write_cfg(0, 0, 0);
    wait_sig(1, 2000, n);
    check("R8 low phase unaffected", n, 11);
    wait_sig(0, 300, n);
    check("R7 no low strobe while held", n, 300);
    check("R7 still high", int'(scl_hi_o), 1);
    scl_in = 1'b1;
    wait_sig(0, 2000, n);
    check_rng("R7 release to low strobe", n, 10, 15);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule